// File: doc/BRIEF.md
# Power-of-Two Region Memory Protection Unit

This block decides, for every bus access, whether the access is allowed. Software programs up to sixteen address windows, each a power of two in size between 1 KB and 4 MB and placed on a boundary equal to its own size. Each window carries a two-bit permission code that says what privileged and user code may do inside it. A separate two-bit code of the same kind governs all accesses that the bus marks as peripheral-space accesses.

A configuration write port loads the descriptors, the master enable and the peripheral code, and a read port returns them. The check port takes an address, a privilege flag, a write flag and a peripheral flag, and answers with a single violation flag in the same cycle. Out of reset the unit is off and never flags anything until software sets the enable.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset the enable reads 0, every descriptor reads 0, the peripheral code reads 2'b11 and `violation` is 0.
- R2: Selector 16 holds the enable in bit 0; while it is 0 `violation` stays 0, and any configuration write changes the checking result only from the clock edge that captures it.
- R3: Selectors 0 to 15 hold descriptors laid out as bit 0 valid, bits 4:1 size code, bits 6:5 permission, bits 31:10 base; bits 9:7 read back as 0 and every other field reads back as written.
- R4: A size code s covers 2^(10+s) bytes; codes 13 to 15 behave as code 12 (4 MB).
- R5: An address hits a valid window when its bits from 10+s upward equal the base bits from 10+s upward; base bits below the window size have no effect.
- R6: Permission codes: 00 denies all accesses, 01 allows privileged only, 10 allows privileged reads and writes and user reads, 11 allows everything.
- R7: When several valid windows cover an address, the one with the highest index decides.
- R8: A non-peripheral address covered by no valid window is allowed; a window with its valid bit clear never matches.
- R9: Selector 17 holds the peripheral code in bits 1:0; an access with `acc_periph` high is judged by that code alone and the windows are not consulted.
- R10: `violation` follows changes of the access inputs in the same cycle, without a clock edge.
- R11: Selectors 18 to 31 read as 0 and writes to them leave all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 5 | Write register selector |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 5 | Read register selector |
| cfg_rdata | output | 32 | Read data for `cfg_raddr` |
| acc_addr | input | 32 | Byte address of the access being checked |
| acc_priv | input | 1 | 1 = privileged state, 0 = user state |
| acc_write | input | 1 | 1 = write, 0 = read or fetch |
| acc_periph | input | 1 | 1 = access targets the peripheral space |
| violation | output | 1 | Protection violation for the current access |

## Verification
The embedded assertions watch, on every cycle, that a disabled unit is silent, that the enable register follows the captured write data, that an open peripheral code and an uncovered address never raise a violation, and that a privileged read is refused only under a deny-all code. Window geometry, the size clamp, overlap priority, the exact effect of each permission code for users, and descriptor readback can only be shown by the bench, which programs random window sets and compares every answer with a reference model, plus directed cases placed on window edges and overlaps.

// File: rtl/mpu_region_guard.sv
module mpu_region_guard #(
  parameter int NREG      = 16,
  parameter int AW        = 32,
  parameter int MIN_SHIFT = 10,
  parameter int MAX_CODE  = 12,
  localparam int SELW     = $clog2(NREG + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_waddr,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [SELW-1:0] cfg_raddr,
  output logic [AW-1:0]   cfg_rdata,
  input  logic [AW-1:0]   acc_addr,
  input  logic            acc_priv,
  input  logic            acc_write,
  input  logic            acc_periph,
  output logic            violation
);
  localparam int BW = AW - MIN_SHIFT;
  localparam int IW = $clog2(NREG);
  localparam logic [SELW-1:0] SEL_EN = SELW'(NREG);
  localparam logic [SELW-1:0] SEL_PP = SELW'(NREG + 1);
  localparam logic [3:0] TOP_CODE = 4'(MAX_CODE);

  logic          en;
  logic [1:0]    pp;
  logic          vld  [NREG];
  logic [3:0]    szc  [NREG];
  logic [1:0]    perm [NREG];
  logic [BW-1:0] base [NREG];
  logic [BW-1:0] mask [NREG];
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [1:0]    eff_perm;
  logic          allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      pp <= 2'b11;
      for (int i = 0; i < NREG; i++) begin
        vld[i]  <= 1'b0;
        szc[i]  <= '0;
        perm[i] <= '0;
        base[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_waddr == SEL_EN) en <= cfg_wdata[0];
      if (cfg_waddr == SEL_PP) pp <= cfg_wdata[1:0];
      for (int i = 0; i < NREG; i++) begin
        if (cfg_waddr == SELW'(i)) begin
          vld[i]  <= cfg_wdata[0];
          szc[i]  <= cfg_wdata[4:1];
          perm[i] <= cfg_wdata[6:5];
          base[i] <= cfg_wdata[AW-1:MIN_SHIFT];
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    assign mask[g] = {BW{1'b1}} << ((szc[g] > TOP_CODE) ? TOP_CODE : szc[g]);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (vld[i] && (((acc_addr[AW-1:MIN_SHIFT] ^ base[i]) & mask[i]) == '0)) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign eff_perm = acc_periph ? pp : (hit ? perm[hit_idx] : 2'b11);

  always_comb begin
    case (eff_perm)
      2'b00:   allow = 1'b0;
      2'b01:   allow = acc_priv;
      2'b10:   allow = acc_priv | ~acc_write;
      default: allow = 1'b1;
    endcase
  end

  assign violation = en & ~allow;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_raddr < SELW'(NREG))
      cfg_rdata = {base[cfg_raddr[IW-1:0]], {(MIN_SHIFT-7){1'b0}},
                   perm[cfg_raddr[IW-1:0]], szc[cfg_raddr[IW-1:0]], vld[cfg_raddr[IW-1:0]]};
    else if (cfg_raddr == SEL_EN)
      cfg_rdata = AW'(en);
    else if (cfg_raddr == SEL_PP)
      cfg_rdata = AW'(pp);
  end

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !violation);
  a_r2_en_update: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_waddr == SEL_EN) |=> (en == $past(cfg_wdata[0])));
  a_r9_periph_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_periph && pp == 2'b11) |-> !violation);
  a_r8_uncovered_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_periph && !hit) |-> !violation);
  a_r6_priv_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_priv && !acc_write && eff_perm != 2'b00) |-> !violation);
endmodule

// File: tb/mpu_region_guard_tb_top.sv
`timescale 1ns/1ps
module mpu_region_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_periph = 1'b0;
  logic        violation;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_word [16];
  logic        m_en;
  logic [1:0]  m_pp;

  always #4 clk = ~clk;

  mpu_region_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_write(acc_write),
    .acc_periph(acc_periph), .violation(violation)
  );

  function automatic int eff_size(input logic [31:0] w);
    int s = int'(w[4:1]);
    return (s > 12) ? 12 : s;
  endfunction

  function automatic logic exp_viol(input logic [31:0] a, input logic pv, input logic wr, input logic pe);
    logic [1:0] p = 2'b11;
    if (!m_en) return 1'b0;
    if (pe) p = m_pp;
    else
      for (int i = 0; i < 16; i++)
        if (m_word[i][0] && ((a >> (10 + eff_size(m_word[i]))) == (m_word[i] >> (10 + eff_size(m_word[i])))))
          p = m_word[i][6:5];
    case (p)
      2'b00:   return 1'b1;
      2'b01:   return !pv;
      2'b10:   return !pv && wr;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 16) m_word[sel] = d & 32'hFFFF_FC7F;
    else if (sel == 16) m_en = d[0];
    else if (sel == 17) m_pp = d[1:0];
  endtask

  task automatic rdchk(input logic [4:0] sel, input logic [31:0] exp, input string req);
    cfg_raddr = sel;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read sel %0d actual %h expected %h", req, sel, cfg_rdata, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic pv, input logic w, input logic pe, input string req);
    logic e;
    acc_addr = a; acc_priv = pv; acc_write = w; acc_periph = pe;
    #1;
    e = exp_viol(a, pv, w, pe);
    checks++;
    if (violation !== e) begin
      errors++;
      $display("FAIL %s addr %h priv %0b wr %0b per %0b actual %0b expected %0b", req, a, pv, w, pe, violation, e);
    end
  endtask

  function automatic logic [31:0] desc(input logic [31:0] b, input int s, input logic [1:0] p, input logic v);
    return (b & 32'hFFFF_FC00) | (32'(p) << 5) | (32'(s[3:0]) << 1) | 32'(v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) m_word[i] = '0;
    m_en = 1'b0; m_pp = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) rdchk(5'(i), 32'h0, "R1");
    rdchk(5'd16, 32'h0, "R1");
    rdchk(5'd17, 32'h3, "R1");
    acc(32'h0000_0100, 1'b0, 1'b1, 1'b0, "R1");

    // R2: deny-all window over 0..1KB, then enable
    wr(5'd0, desc(32'h0, 0, 2'b00, 1'b1));
    acc(32'h0000_0100, 1'b1, 1'b0, 1'b0, "R2");
    cfg_we = 1'b1; cfg_waddr = 5'd16; cfg_wdata = 32'h1;
    #1;
    checks++;
    if (violation !== 1'b0) begin errors++; $display("FAIL R2 before edge actual %0b expected 0", violation); end
    @(posedge clk); #1;
    m_en = 1'b1;
    checks++;
    if (violation !== 1'b1) begin errors++; $display("FAIL R2 after edge actual %0b expected 1", violation); end
    @(negedge clk); cfg_we = 1'b0;
    rdchk(5'd16, 32'h1, "R2");

    // R10: same-cycle response to access inputs
    acc(32'h0000_0400, 1'b1, 1'b0, 1'b0, "R10");
    acc(32'h0000_03FC, 1'b1, 1'b0, 1'b0, "R10");

    // R3 readback, low bits dropped
    wr(5'd9, 32'hABCD_E3F5);
    rdchk(5'd9, 32'hABCD_E075, "R3");
    wr(5'd9, 32'h0);

    // R7 overlap: big deny window under a small open window
    wr(5'd3, desc(32'h2000_0000, 12, 2'b00, 1'b1));
    wr(5'd5, desc(32'h2000_0000, 0, 2'b11, 1'b1));
    acc(32'h2000_0100, 1'b0, 1'b1, 1'b0, "R7");
    acc(32'h2000_0400, 1'b1, 1'b0, 1'b0, "R7");

    // R4 clamp with code 15, R5 base low bits ignored
    wr(5'd7, desc(32'h3012_3400, 15, 2'b01, 1'b1));
    acc(32'h303F_FFFC, 1'b0, 1'b0, 1'b0, "R4");
    acc(32'h3000_0000, 1'b0, 1'b0, 1'b0, "R5");
    acc(32'h3040_0000, 1'b0, 1'b1, 1'b0, "R4");
    acc(32'h2FFF_FFFC, 1'b0, 1'b1, 1'b0, "R5");

    // R6 user read-only window
    wr(5'd8, desc(32'h4000_8000, 5, 2'b10, 1'b1));
    acc(32'h4000_8010, 1'b0, 1'b0, 1'b0, "R6");
    acc(32'h4000_8010, 1'b0, 1'b1, 1'b0, "R6");
    acc(32'h4000_8010, 1'b1, 1'b1, 1'b0, "R6");

    // R8 invalid window ignored, uncovered allowed
    wr(5'd10, desc(32'h5000_0000, 3, 2'b00, 1'b0));
    acc(32'h5000_0000, 1'b0, 1'b1, 1'b0, "R8");
    acc(32'h7000_0000, 1'b0, 1'b1, 1'b0, "R8");

    // R9 peripheral code
    acc(32'h2000_0400, 1'b0, 1'b1, 1'b1, "R9");
    wr(5'd17, 32'h0);
    rdchk(5'd17, 32'h0, "R9");
    acc(32'h7000_0000, 1'b1, 1'b0, 1'b1, "R9");
    wr(5'd17, 32'h2);
    acc(32'hFFFF_F000, 1'b0, 1'b1, 1'b1, "R9");
    acc(32'hFFFF_F000, 1'b0, 1'b0, 1'b1, "R9");

    // R11 unmapped selectors
    wr(5'd20, 32'hFFFF_FFFF);
    wr(5'd31, 32'hFFFF_FFFF);
    rdchk(5'd20, 32'h0, "R11");
    rdchk(5'd31, 32'h0, "R11");
    rdchk(5'd16, 32'h1, "R11");
    rdchk(5'd17, 32'h2, "R11");
    rdchk(5'd7, m_word[7], "R11");
    rdchk(5'd4, 32'h0, "R11");

    // Random window sets
    for (int r = 0; r < 24; r++) begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] d = $urandom;
        d[31:28] = 4'($urandom_range(0, 3));
        wr(5'(i), d);
        rdchk(5'(i), m_word[i], "R3");
      end
      wr(5'd17, 32'($urandom_range(0, 3)));
      wr(5'd16, (r % 6 == 5) ? 32'h0 : 32'h1);
      for (int k = 0; k < 150; k++) begin
        int j = $urandom_range(0, 15);
        int s = eff_size(m_word[j]);
        logic [31:0] a = (m_word[j] & 32'hFFFF_FC00) + 32'($urandom % (32'h1 << (11 + s))) - (32'h1 << (9 + s));
        if (k % 9 == 0) a = $urandom;
        acc(a, 1'($urandom), 1'($urandom), (k % 13 == 0), "R7");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule